// File: doc/BRIEF.md
# Masked Vector Register Write Unit

This block holds a vector register file of 32 registers with 64 elements of 64 bits each. Alongside it sit a vector-length register, eight one-bit-per-element mask registers and a one-bit-per-element carry register. A vector write carries a full vector of element data, a destination register and a mask selector. It lands only on element positions that lie below the current length and whose bit in the selected mask is 1. Every other position keeps its old contents.

Only the lower four masks may govern a write. Selecting one of the upper four rejects the whole operation and raises a one-cycle error flag. Masks are loaded whole from a comparison result, and any mask can be copied into any other in one cycle. This lets an upper mask be moved into a usable slot. The carry register is written under exactly the same per-element enables as the vector data. Read ports expose one vector register, one mask, the length and the carry register, all combinationally.

Top module: `mvw_unit`

## Requirements
- R1: A length write stores the value when it is 64 or below. A larger value is stored as 64. The length reads back on `vl_o` from the cycle after the write.
- R2: A vector write updates element e of the destination, found at bits [64e+63:64e] of the data and read ports, only when e < length and bit e of the selected mask is 1. All other elements of that register and all other registers keep their values.
- R3: With a length of 0, a vector write changes no element and no carry bit.
- R4: A mask selector of 4 to 7 on a vector write changes no element and no carry bit. `err_o` is then 1 for exactly the following cycle. At all other times `err_o` is 0.
- R5: When carry update is requested with a vector write, carry bit e takes bit e of the carry input under exactly the element enables of R2. The other carry bits hold.
- R6: A comparison load writes all 64 bits of the addressed mask in one cycle.
- R7: A mask move copies the source mask into the destination mask in one cycle. If a comparison load targets the same destination in the same cycle, the comparison load wins.
- R8: A vector write uses the length and mask values held before its clock edge. A length write or mask update in the same cycle only affects later operations.
- R9: After reset the length, all masks, the carry register, all elements and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vl_we_i | input | 1 | Length write strobe |
| vl_wdata_i | input | 7 | Requested length, saturated to 64 |
| vl_o | output | 7 | Current length |
| vwr_valid_i | input | 1 | Vector write request |
| vwr_dst_i | input | 5 | Destination vector register |
| vwr_msel_i | input | 3 | Governing mask; 0 to 3 legal |
| vwr_data_i | input | 4096 | Element data, element e at [64e+63:64e] |
| vwr_carry_we_i | input | 1 | Also update carry register |
| vwr_carry_i | input | 64 | Carry input, bit e per element |
| mk_cmp_we_i | input | 1 | Comparison result load strobe |
| mk_cmp_dst_i | input | 3 | Mask loaded from comparison |
| mk_cmp_i | input | 64 | Comparison result bits |
| mk_mv_we_i | input | 1 | Mask move strobe |
| mk_mv_src_i | input | 3 | Move source mask |
| mk_mv_dst_i | input | 3 | Move destination mask |
| vrd_sel_i | input | 5 | Vector register read select |
| vrd_data_o | output | 4096 | Selected vector register contents |
| mk_rd_sel_i | input | 3 | Mask read select |
| mk_rd_o | output | 64 | Selected mask contents |
| vc_o | output | 64 | Carry register |
| err_o | output | 1 | Illegal mask selector flag |

## Verification
The write path is driven with a full mask at full length, which shows that every element path is live. An alternating mask under a short length separates the mask gate from the length gate. The bench also uses a length of zero, a saturated over-range length, a length of one, a mask set only at both ends and a length of 63, which together probe the low and high edges of the length comparison. An upper-mask selector checks that rejection leaves data and carry untouched. Further directed cases cover a mask move from an upper mask followed by its use, a comparison load colliding with a move, a length change in the same cycle as a write, and a partial overwrite of earlier data.

// File: rtl/mvw_pkg.sv
package mvw_pkg;
  parameter int unsigned NUM_VREG  = 32;
  parameter int unsigned NUM_ELEM  = 64;
  parameter int unsigned ELEM_W    = 64;
  parameter int unsigned NUM_MASK  = 8;
  parameter int unsigned NUM_CTRL  = 4;

  localparam int unsigned VSEL_W = $clog2(NUM_VREG);
  localparam int unsigned MSEL_W = $clog2(NUM_MASK);
  localparam int unsigned VL_W   = $clog2(NUM_ELEM) + 1;
  localparam int unsigned VEC_W  = NUM_ELEM * ELEM_W;
endpackage

// File: rtl/mvw_enable_gen.sv
module mvw_enable_gen
  import mvw_pkg::*;
#(
  parameter int unsigned NE     = NUM_ELEM,
  parameter int unsigned NM     = NUM_MASK,
  parameter int unsigned NCTRL  = NUM_CTRL,
  localparam int unsigned MW    = $clog2(NM),
  localparam int unsigned LW    = $clog2(NE) + 1
) (
  input  logic                   valid_i,
  input  logic [MW-1:0]          msel_i,
  input  logic [LW-1:0]          vl_i,
  input  logic [NM-1:0][NE-1:0]  mask_i,
  output logic [NE-1:0]          en_o,
  output logic                   bad_o
);
  logic          legal;
  logic [NE-1:0] sel_mask;

  assign legal    = (32'(msel_i) < NCTRL);
  assign bad_o    = valid_i && !legal;
  assign sel_mask = mask_i[msel_i];

  for (genvar e = 0; e < NE; e++) begin : g_en
    assign en_o[e] = valid_i && legal && (LW'(e) < vl_i) && sel_mask[e];
  end
endmodule

// File: rtl/mvw_mask_file.sv
module mvw_mask_file
  import mvw_pkg::*;
#(
  parameter int unsigned NE = NUM_ELEM,
  parameter int unsigned NM = NUM_MASK,
  localparam int unsigned MW = $clog2(NM)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmp_we_i,
  input  logic [MW-1:0]         cmp_dst_i,
  input  logic [NE-1:0]         cmp_i,
  input  logic                  mv_we_i,
  input  logic [MW-1:0]         mv_src_i,
  input  logic [MW-1:0]         mv_dst_i,
  output logic [NM-1:0][NE-1:0] mask_o
);
  logic [NM-1:0][NE-1:0] mask_q;
  logic [NE-1:0]         mv_val;

  assign mv_val = mask_q[mv_src_i];
  assign mask_o = mask_q;

  for (genvar m = 0; m < NM; m++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[m] <= '0;
      end else if (cmp_we_i && cmp_dst_i == MW'(m)) begin
        mask_q[m] <= cmp_i;  // comparison load wins over move
      end else if (mv_we_i && mv_dst_i == MW'(m)) begin
        mask_q[m] <= mv_val;
      end
    end
  end
endmodule

// File: rtl/mvw_vreg_file.sv
module mvw_vreg_file
  import mvw_pkg::*;
#(
  parameter int unsigned NV = NUM_VREG,
  parameter int unsigned NE = NUM_ELEM,
  parameter int unsigned EW = ELEM_W,
  localparam int unsigned SW = $clog2(NV),
  localparam int unsigned VW = NE * EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NE-1:0] en_i,
  input  logic [SW-1:0] dst_i,
  input  logic [VW-1:0] data_i,
  input  logic          carry_we_i,
  input  logic [NE-1:0] carry_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [VW-1:0] rd_data_o,
  output logic [NE-1:0] vc_o
);
  logic [EW-1:0] mem_q [NV][NE];
  logic [NE-1:0] vc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NV; r++) begin
        for (int e = 0; e < NE; e++) mem_q[r][e] <= '0;
      end
    end else begin
      for (int e = 0; e < NE; e++) begin
        if (en_i[e]) mem_q[dst_i][e] <= data_i[e*EW +: EW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vc_q <= '0;
    end else if (carry_we_i) begin
      for (int e = 0; e < NE; e++) begin
        if (en_i[e]) vc_q[e] <= carry_i[e];
      end
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_rd
    assign rd_data_o[e*EW +: EW] = mem_q[rd_sel_i][e];
  end

  assign vc_o = vc_q;
endmodule

// File: rtl/mvw_unit.sv
module mvw_unit
  import mvw_pkg::*;
#(
  parameter int unsigned NV    = NUM_VREG,
  parameter int unsigned NE    = NUM_ELEM,
  parameter int unsigned EW    = ELEM_W,
  parameter int unsigned NM    = NUM_MASK,
  parameter int unsigned NCTRL = NUM_CTRL,
  localparam int unsigned SW   = $clog2(NV),
  localparam int unsigned MW   = $clog2(NM),
  localparam int unsigned LW   = $clog2(NE) + 1,
  localparam int unsigned VW   = NE * EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vl_we_i,
  input  logic [LW-1:0] vl_wdata_i,
  output logic [LW-1:0] vl_o,
  input  logic          vwr_valid_i,
  input  logic [SW-1:0] vwr_dst_i,
  input  logic [MW-1:0] vwr_msel_i,
  input  logic [VW-1:0] vwr_data_i,
  input  logic          vwr_carry_we_i,
  input  logic [NE-1:0] vwr_carry_i,
  input  logic          mk_cmp_we_i,
  input  logic [MW-1:0] mk_cmp_dst_i,
  input  logic [NE-1:0] mk_cmp_i,
  input  logic          mk_mv_we_i,
  input  logic [MW-1:0] mk_mv_src_i,
  input  logic [MW-1:0] mk_mv_dst_i,
  input  logic [SW-1:0] vrd_sel_i,
  output logic [VW-1:0] vrd_data_o,
  input  logic [MW-1:0] mk_rd_sel_i,
  output logic [NE-1:0] mk_rd_o,
  output logic [NE-1:0] vc_o,
  output logic          err_o
);
  logic [LW-1:0]         vl_q;
  logic [NM-1:0][NE-1:0] mask_q;
  logic [NE-1:0]         elem_en;
  logic                  bad_sel;
  logic                  err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (vl_we_i) vl_q <= (32'(vl_wdata_i) > NE) ? LW'(NE) : vl_wdata_i;
      err_q <= bad_sel;
    end
  end

  mvw_mask_file #(.NE(NE), .NM(NM)) u_masks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_we_i  (mk_cmp_we_i),
    .cmp_dst_i (mk_cmp_dst_i),
    .cmp_i     (mk_cmp_i),
    .mv_we_i   (mk_mv_we_i),
    .mv_src_i  (mk_mv_src_i),
    .mv_dst_i  (mk_mv_dst_i),
    .mask_o    (mask_q)
  );

  mvw_enable_gen #(.NE(NE), .NM(NM), .NCTRL(NCTRL)) u_en (
    .valid_i (vwr_valid_i),
    .msel_i  (vwr_msel_i),
    .vl_i    (vl_q),
    .mask_i  (mask_q),
    .en_o    (elem_en),
    .bad_o   (bad_sel)
  );

  mvw_vreg_file #(.NV(NV), .NE(NE), .EW(EW)) u_vrf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (elem_en),
    .dst_i      (vwr_dst_i),
    .data_i     (vwr_data_i),
    .carry_we_i (vwr_carry_we_i),
    .carry_i    (vwr_carry_i),
    .rd_sel_i   (vrd_sel_i),
    .rd_data_o  (vrd_data_o),
    .vc_o       (vc_o)
  );

  assign vl_o    = vl_q;
  assign mk_rd_o = mask_q[mk_rd_sel_i];
  assign err_o   = err_q;
endmodule

// File: rtl/mvw_unit_chk.sv
module mvw_unit_chk
  import mvw_pkg::*;
#(
  parameter int unsigned NE    = NUM_ELEM,
  parameter int unsigned NM    = NUM_MASK,
  parameter int unsigned NCTRL = NUM_CTRL,
  localparam int unsigned MW   = $clog2(NM),
  localparam int unsigned LW   = $clog2(NE) + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  vl_we_i,
  input logic [LW-1:0]         vl_wdata_i,
  input logic [LW-1:0]         vl_o,
  input logic                  vwr_valid_i,
  input logic [MW-1:0]         vwr_msel_i,
  input logic                  vwr_carry_we_i,
  input logic                  mk_cmp_we_i,
  input logic [MW-1:0]         mk_cmp_dst_i,
  input logic [NE-1:0]         mk_cmp_i,
  input logic                  mk_mv_we_i,
  input logic [MW-1:0]         mk_mv_src_i,
  input logic [MW-1:0]         mk_mv_dst_i,
  input logic [NM-1:0][NE-1:0] mask_q,
  input logic [NE-1:0]         vc_o,
  input logic                  err_o
);
  logic          bad_req;
  logic [NE-1:0] allow;

  assign bad_req = vwr_valid_i && (32'(vwr_msel_i) >= NCTRL);

  // positions a legal write may touch, from observed length and mask state
  always_comb begin
    for (int e = 0; e < NE; e++) begin
      allow[e] = (e < 32'(vl_o)) && mask_q[vwr_msel_i][e];
    end
  end

  p_vl_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(vl_o) <= NE);

  p_vl_sat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_we_i && 32'(vl_wdata_i) > NE |=> 32'(vl_o) == NE);

  p_zero_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_o == '0 && !vl_we_i |=> $stable(vc_o) && vl_o == '0);

  p_err_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_req |=> err_o);

  p_err_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_req |=> !err_o);

  p_bad_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_req |=> $stable(vc_o));

  p_carry_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vwr_valid_i && vwr_carry_we_i) |=> $stable(vc_o));

  p_carry_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vwr_valid_i && !bad_req |=> ((vc_o ^ $past(vc_o)) & ~$past(allow)) == '0);

  p_cmp_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_cmp_we_i |=> mask_q[$past(mk_cmp_dst_i)] == $past(mk_cmp_i));

  p_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_mv_we_i && !(mk_cmp_we_i && mk_cmp_dst_i == mk_mv_dst_i)
    |=> mask_q[$past(mk_mv_dst_i)] == $past(mask_q[mk_mv_src_i]));
endmodule

bind mvw_unit mvw_unit_chk #(.NE(NE), .NM(NM), .NCTRL(NCTRL)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .vl_we_i        (vl_we_i),
  .vl_wdata_i     (vl_wdata_i),
  .vl_o           (vl_o),
  .vwr_valid_i    (vwr_valid_i),
  .vwr_msel_i     (vwr_msel_i),
  .vwr_carry_we_i (vwr_carry_we_i),
  .mk_cmp_we_i    (mk_cmp_we_i),
  .mk_cmp_dst_i   (mk_cmp_dst_i),
  .mk_cmp_i       (mk_cmp_i),
  .mk_mv_we_i     (mk_mv_we_i),
  .mk_mv_src_i    (mk_mv_src_i),
  .mk_mv_dst_i    (mk_mv_dst_i),
  .mask_q         (mask_q),
  .vc_o           (vc_o),
  .err_o          (err_o)
);

// File: tb/mvw_unit_bench.sv
`timescale 1ns/1ps
module mvw_unit_bench;
  localparam int NV = 32;
  localparam int NE = 64;
  localparam int EW = 64;
  localparam int VW = NE * EW;

  typedef struct packed {
    logic [6:0]  vl;
    logic [2:0]  msel;
    logic [4:0]  dst;
    logic [63:0] mask;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{7'd64,  3'd0, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF},  // full length, full mask
    '{7'd10,  3'd1, 5'd2, 64'hAAAA_AAAA_AAAA_AAAA},  // short length, alternating mask
    '{7'd0,   3'd2, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF},  // zero length
    '{7'd100, 3'd3, 5'd4, 64'hF0F0_F0F0_F0F0_F0F0},  // over-range length saturates
    '{7'd33,  3'd5, 5'd5, 64'hFFFF_FFFF_FFFF_FFFF},  // upper mask rejected
    '{7'd1,   3'd0, 5'd6, 64'hFFFF_FFFF_FFFF_FFFF},  // single element
    '{7'd64,  3'd2, 5'd7, 64'h8000_0000_0000_0001},  // end bits only
    '{7'd63,  3'd3, 5'd8, 64'hFFFF_FFFF_FFFF_FFFE}   // length 63
  };

  logic          clk;
  logic          rst_n;
  logic          vl_we;
  logic [6:0]    vl_wdata;
  logic [6:0]    vl_out;
  logic          vwr_valid;
  logic [4:0]    vwr_dst;
  logic [2:0]    vwr_msel;
  logic [VW-1:0] vwr_data;
  logic          vwr_cwe;
  logic [NE-1:0] vwr_cin;
  logic          cmp_we;
  logic [2:0]    cmp_dst;
  logic [NE-1:0] cmp_val;
  logic          mv_we;
  logic [2:0]    mv_src;
  logic [2:0]    mv_dst;
  logic [4:0]    rd_sel;
  logic [VW-1:0] rd_data;
  logic [2:0]    mrd_sel;
  logic [NE-1:0] mrd;
  logic [NE-1:0] vc;
  logic          err;

  mvw_unit u_mvw_unit (
    .clk_i (clk), .rst_ni (rst_n),
    .vl_we_i (vl_we), .vl_wdata_i (vl_wdata), .vl_o (vl_out),
    .vwr_valid_i (vwr_valid), .vwr_dst_i (vwr_dst), .vwr_msel_i (vwr_msel),
    .vwr_data_i (vwr_data), .vwr_carry_we_i (vwr_cwe), .vwr_carry_i (vwr_cin),
    .mk_cmp_we_i (cmp_we), .mk_cmp_dst_i (cmp_dst), .mk_cmp_i (cmp_val),
    .mk_mv_we_i (mv_we), .mk_mv_src_i (mv_src), .mk_mv_dst_i (mv_dst),
    .vrd_sel_i (rd_sel), .vrd_data_o (rd_data),
    .mk_rd_sel_i (mrd_sel), .mk_rd_o (mrd), .vc_o (vc), .err_o (err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] exp_mem [NV][NE];
  logic [63:0] exp_mask [8];
  logic [63:0] exp_vc;
  int          exp_vl;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input int r);
    int bad = -1;
    rd_sel = 5'(r);
    #1;
    for (int e = 0; e < NE; e++) begin
      if (bad < 0 && rd_data[e*EW +: EW] !== exp_mem[r][e]) bad = e;
    end
    n_chk++;
    if (bad >= 0) begin
      n_err++;
      $display("FAIL %s: reg %0d elem %0d actual %h expected %h",
               tag, r, bad, rd_data[bad*EW +: EW], exp_mem[r][bad]);
    end
  endtask

  task automatic chk_mask(input string tag, input int m);
    mrd_sel = 3'(m);
    #1;
    chk(tag, mrd, exp_mask[m]);
  endtask

  function automatic logic [63:0] elem(input int seed, input int e);
    return {8'hC5, seed[23:0], e[31:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    vl_we = 0; vwr_valid = 0; vwr_cwe = 0; cmp_we = 0; mv_we = 0;
  endtask

  // drive a write; expectations use length and masks held before the edge
  task automatic drive_write(input int dst, input int msel, input int seed, input logic [63:0] cin);
    vwr_valid = 1; vwr_dst = 5'(dst); vwr_msel = 3'(msel);
    vwr_cwe = 1; vwr_cin = cin;
    for (int e = 0; e < NE; e++) vwr_data[e*EW +: EW] = elem(seed, e);
    if (msel < 4) begin
      for (int e = 0; e < NE; e++) begin
        if (e < exp_vl && exp_mask[msel][e]) begin
          exp_mem[dst][e] = elem(seed, e);
          exp_vc[e] = cin[e];
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0; vl_wdata = '0; vwr_dst = '0; vwr_msel = '0; vwr_data = '0;
    vwr_cin = '0; cmp_dst = '0; cmp_val = '0; mv_src = '0; mv_dst = '0;
    rd_sel = '0; mrd_sel = '0;
    for (int r = 0; r < NV; r++) for (int e = 0; e < NE; e++) exp_mem[r][e] = '0;
    for (int m = 0; m < 8; m++) exp_mask[m] = '0;
    exp_vc = '0; exp_vl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 reset state
    chk("R9 length", 64'(vl_out), 64'd0);
    chk("R9 carry", vc, 64'd0);
    chk("R9 err", 64'(err), 64'd0);
    chk_mask("R9 mask7", 7);
    chk_vec("R9 reg0", 0);
    chk_vec("R9 reg31", 31);

    // table of vectors
    for (int i = 0; i < 8; i++) begin
      cmp_we = 1; cmp_dst = ROWS[i].msel; cmp_val = ROWS[i].mask;
      vl_we = 1; vl_wdata = ROWS[i].vl;
      step(); idle();
      exp_mask[ROWS[i].msel] = ROWS[i].mask;
      exp_vl = (ROWS[i].vl > 64) ? 64 : int'(ROWS[i].vl);
      chk("R1 length", 64'(vl_out), 64'(exp_vl));
      chk_mask("R6 compare load", int'(ROWS[i].msel));
      drive_write(int'(ROWS[i].dst), int'(ROWS[i].msel), i + 1,
                  {32{2'b10}} ^ {64{i[0]}});
      step(); idle();
      chk("R4 error flag", 64'(err), 64'(ROWS[i].msel >= 4));
      chk_vec("R2 R3 R4 table write", int'(ROWS[i].dst));
      chk("R5 carry", vc, exp_vc);
    end

    // R4 flag lasts one cycle
    step();
    chk("R4 error clears", 64'(err), 64'd0);

    // R7 move upper mask 5 into slot 1, then use it
    mv_we = 1; mv_src = 3'd5; mv_dst = 3'd1;
    step(); idle();
    exp_mask[1] = exp_mask[5];
    chk_mask("R7 move", 1);
    drive_write(10, 1, 20, 64'h0123_4567_89AB_CDEF);
    step(); idle();
    chk_vec("R7 write via moved mask", 10);
    chk("R5 carry via moved mask", vc, exp_vc);

    // R7 collision: comparison load beats move on same destination
    cmp_we = 1; cmp_dst = 3'd2; cmp_val = 64'h0000_FFFF_0000_1234;
    mv_we = 1; mv_src = 3'd5; mv_dst = 3'd2;
    step(); idle();
    exp_mask[2] = 64'h0000_FFFF_0000_1234;
    chk_mask("R7 compare wins", 2);

    // R8 length change in the same cycle as a write (old length 63 applies)
    cmp_we = 1; cmp_dst = 3'd0; cmp_val = 64'h0;  // same-cycle mask clear ignored by write
    vl_we = 1; vl_wdata = 7'd4;
    drive_write(9, 0, 30, 64'hFFFF_FFFF_FFFF_FFFF);
    step(); idle();
    exp_mask[0] = 64'h0;
    exp_vl = 4;
    chk_vec("R8 old length and mask", 9);
    chk("R8 new length", 64'(vl_out), 64'd4);

    // R2 partial overwrite with length 4
    cmp_we = 1; cmp_dst = 3'd0; cmp_val = 64'hFFFF_FFFF_FFFF_FFFF;
    step(); idle();
    exp_mask[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    drive_write(9, 0, 31, 64'h0);
    step(); idle();
    chk_vec("R2 partial overwrite", 9);
    chk("R5 partial carry", vc, exp_vc);
    chk_vec("R2 other reg untouched", 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule